// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error-Tagged Receive Queue

This block is the receiving side of a start-stop serial port. A 16x oversampling strobe from an external rate generator paces a frame engine that hunts for a falling edge on the line, confirms it at the middle of the start bit and then samples every following bit at its centre. The engine assembles 7-bit or 8-bit characters, checks an optional even or odd parity bit, and checks one or two stop bits.

Each completed character goes into a 16-entry first-in first-out queue together with its own parity and framing flags. The queue head is always visible on the read port, and a read strobe removes it. The block reports the fill level and a running count of stored characters that carry an error. A line held low for a whole frame is reported as a break, not stored. A time-out flag marks a queue that holds a few characters while the line has gone quiet. Flow control and service requests are derived from the fill level: a ready-to-send output, a fill request for an interrupt or DMA engine, an error request and a break request.

Top module: `async_rx_errfifo`

## Requirements
- R1: A low level on the line seen on a strobe in idle starts a frame; the frame is kept only if the line is still low on the 8th strobe after that one. Otherwise the engine goes back to idle and stores nothing.
- R2: Data bits are sampled on the 8th strobe of each 16-strobe bit period, least significant bit first. `cfg_eight`=1 gives 8 data bits; `cfg_eight`=0 gives 7, and then `rd_data[7]` reads 0.
- R3: `cfg_parity` 1 selects even parity, 2 selects odd parity, and 0 or 3 selects no parity bit. A character whose parity bit does not match is stored with `rd_perr`=1.
- R4: `cfg_two_stop` selects one or two stop bits. A character with a stop sample of 0 is stored with `rd_ferr`=1.
- R5: A character is stored on the clock edge that samples its final stop bit, and `rx_count` shows it from the next cycle on. Up to 16 characters are held in arrival order. `rd_data`/`rd_perr`/`rd_ferr` show the oldest one, and `rd_en` removes it when the queue is not empty.
- R6: `err_count` equals the number of stored characters with a parity or framing flag, and `req_err` is high whenever it is non-zero.
- R7: A character that completes while `rx_count` is 16 is dropped, even if a read happens in the same cycle. The drop sets `overrun`, which stays high until `flag_clr`.
- R8: A frame whose every sample is 0, up to and including its final stop bit, is a break. It is not stored. It sets `req_brk`, which stays high until `flag_clr`. The engine starts no new frame until it has sampled the line high.
- R9: When the queue holds at least one character but fewer than `rx_trig`, and no frame has ended and no read has happened for 15 frame times (frame bits x 16 strobes), `timeout_flag` sets. A read clears it.
- R10: `rts` is high while `rx_count` is below `rts_level` and low otherwise.
- R11: `req_full` is high while `rx_count` is at or above `rx_trig`.
- R12: After reset the queue is empty, both counts are 0, `rts` is high and every flag and request is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling strobe, 16 per bit |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_eight | input | 1 | 1: eight data bits, 0: seven |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one |
| cfg_parity | input | 2 | 0/3 none, 1 even, 2 odd |
| rx_trig | input | 5 | Fill level that raises the fill request |
| rts_level | input | 5 | Fill level at which `rts` drops |
| rd_en | input | 1 | Removes the head character |
| flag_clr | input | 1 | Clears the break and overrun flags |
| rd_data | output | 8 | Head character data |
| rd_perr | output | 1 | Head character parity error |
| rd_ferr | output | 1 | Head character framing error |
| rx_count | output | 5 | Characters stored |
| err_count | output | 5 | Stored characters carrying an error |
| rts | output | 1 | Ready to send (flow control) |
| req_full | output | 1 | Fill request |
| req_err | output | 1 | Receive error request |
| req_brk | output | 1 | Break request |
| timeout_flag | output | 1 | Idle time-out with data waiting |
| overrun | output | 1 | Character lost to a full queue |

## Verification
The bench builds the block with its defaults, DEPTH=16 and TOUT_FRAMES=15, and holds the oversampling strobe high, so a bit lasts 16 clocks. At that rate seventeen back-to-back frames take under 3,000 cycles and overrun the queue. The 2,400-strobe time-out of an eight-bit, no-parity, one-stop frame also fits easily in a run. A queue-based model follows every frame the bench sends, so parity flips, a bad first stop bit, a short glitch and a held-low line are each compared with the model on every clock.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  localparam int RX_DW = 8;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_OFF  = 2'd3
  } par_mode_e;

  typedef struct packed {
    logic             perr;
    logic             ferr;
    logic [RX_DW-1:0] data;
  } rx_entry_t;

  // start + 7 data + 1 stop, plus the optional pieces
  function automatic int unsigned bits_per_frame(logic eight, logic par_on, logic two);
    return 32'd9 + 32'(eight) + 32'(par_on) + 32'(two);
  endfunction

  function automatic int unsigned idle_ticks(int unsigned frames, logic eight,
                                             logic par_on, logic two);
    return frames * bits_per_frame(eight, par_on, two) * 32'd16;
  endfunction

  function automatic logic parity_enabled(logic [1:0] mode);
    return (mode == PAR_EVEN) || (mode == PAR_ODD);
  endfunction

  function automatic logic parity_fails(logic [RX_DW-1:0] d, logic pbit, logic odd);
    return (^d ^ pbit) != odd;
  endfunction
endpackage

// File: rtl/rx_frame_sampler.sv
module rx_frame_sampler
  import async_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rxd,
  input  logic      eight,
  input  logic      two_stop,
  input  logic [1:0] par_mode,
  output logic      done_ev,
  output logic      brk_ev,
  output rx_entry_t char_o
);
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2, S_HOLD
  } smp_state_e;

  smp_state_e       state;
  logic [3:0]       phase;
  logic [2:0]       bidx;
  logic [RX_DW-1:0] shreg;
  logic             pbit;
  logic             stop1_bad;
  logic             all_low;

  logic par_on, odd, mid, last_bit, last_stop_mid, frame_zero;
  assign par_on        = parity_enabled(par_mode);
  assign odd           = (par_mode == PAR_ODD);
  assign mid           = tick && (phase == 4'd7);
  assign last_bit      = (bidx == (eight ? 3'd7 : 3'd6));
  assign last_stop_mid = mid && ((state == S_STOP1 && !two_stop) || state == S_STOP2);
  assign frame_zero    = all_low && !rxd;
  assign brk_ev        = last_stop_mid && frame_zero;
  assign done_ev       = last_stop_mid && !frame_zero;

  always_comb begin
    char_o.data = shreg;
    char_o.perr = par_on && parity_fails(shreg, pbit, odd);
    char_o.ferr = !rxd || (state == S_STOP2 && stop1_bad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      phase     <= '0;
      bidx      <= '0;
      shreg     <= '0;
      pbit      <= 1'b0;
      stop1_bad <= 1'b0;
      all_low   <= 1'b0;
    end else if (tick) begin
      phase <= (state == S_IDLE || state == S_HOLD) ? 4'd0 : phase + 4'd1;
      case (state)
        S_IDLE: if (!rxd) begin
          state     <= S_START;
          shreg     <= '0;
          bidx      <= '0;
          stop1_bad <= 1'b0;
          all_low   <= 1'b1;
        end
        S_START: begin
          if (phase == 4'd7 && rxd) state <= S_IDLE;
          else if (phase == 4'd15)  state <= S_DATA;
        end
        S_DATA: begin
          if (phase == 4'd7) begin
            shreg[bidx] <= rxd;
            if (rxd) all_low <= 1'b0;
          end
          if (phase == 4'd15) begin
            if (last_bit) state <= par_on ? S_PAR : S_STOP1;
            else          bidx  <= bidx + 3'd1;
          end
        end
        S_PAR: begin
          if (phase == 4'd7) begin
            pbit <= rxd;
            if (rxd) all_low <= 1'b0;
          end
          if (phase == 4'd15) state <= S_STOP1;
        end
        S_STOP1: begin
          if (phase == 4'd7) begin
            if (two_stop) begin
              stop1_bad <= !rxd;
              if (rxd) all_low <= 1'b0;
            end else begin
              state <= frame_zero ? S_HOLD : S_IDLE;
            end
          end else if (phase == 4'd15) begin
            state <= S_STOP2;
          end
        end
        S_STOP2: if (phase == 4'd7) state <= frame_zero ? S_HOLD : S_IDLE;
        S_HOLD:  if (rxd) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1
  false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_START && mid && rxd) |=> state == S_IDLE);
  // R8
  brk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_ev |=> state == S_HOLD);
  // R8
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD && !rxd) |=> state == S_HOLD);
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
  import async_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  rx_entry_t     push_entry,
  input  logic          pop,
  output rx_entry_t     head,
  output logic [CW-1:0] count,
  output logic [CW-1:0] err_count,
  output logic          push_ok,
  output logic          pop_ok
);
  function automatic logic [CW-1:0] step_level(logic [CW-1:0] lvl, logic up, logic down);
    return lvl + CW'(up) - CW'(down);
  endfunction

  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          in_tag, out_tag;

  assign push_ok = push && (count != CW'(DEPTH));
  assign pop_ok  = pop && (count != '0);
  assign head    = mem[rptr];
  assign in_tag  = push_entry.perr || push_entry.ferr;
  assign out_tag = head.perr || head.ferr;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr      <= '0;
      rptr      <= '0;
      count     <= '0;
      err_count <= '0;
    end else begin
      if (push_ok) wptr <= wptr + AW'(1);
      if (pop_ok)  rptr <= rptr + AW'(1);
      count     <= step_level(count, push_ok, pop_ok);
      err_count <= step_level(err_count, push_ok && in_tag, pop_ok && out_tag);
    end
  end

  // R5
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R6
  err_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_count <= count);
  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && count == '0) |=> count == '0);
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          armed,
  input  logic          restart,
  input  logic          clear,
  input  logic [TW-1:0] limit,
  output logic          flag
);
  logic [TW-1:0] tcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
      flag <= 1'b0;
    end else if (restart || clear) begin
      tcnt <= '0;
      if (clear) flag <= 1'b0;
    end else if (!armed) begin
      tcnt <= '0;
    end else if (tick && !flag) begin
      if (tcnt == limit - TW'(1)) begin
        flag <= 1'b1;
        tcnt <= '0;
      end else begin
        tcnt <= tcnt + TW'(1);
      end
    end
  end

  // R9
  tout_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(armed));
  // R9
  tout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !flag);
endmodule

// File: rtl/async_rx_errfifo.sv
module async_rx_errfifo
  import async_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TOUT_FRAMES = 15,
  localparam int CW = $clog2(DEPTH) + 1,
  localparam int TW = $clog2(TOUT_FRAMES * 12 * 16 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          rxd,
  input  logic          cfg_eight,
  input  logic          cfg_two_stop,
  input  logic [1:0]    cfg_parity,
  input  logic [CW-1:0] rx_trig,
  input  logic [CW-1:0] rts_level,
  input  logic          rd_en,
  input  logic          flag_clr,
  output logic [7:0]    rd_data,
  output logic          rd_perr,
  output logic          rd_ferr,
  output logic [CW-1:0] rx_count,
  output logic [CW-1:0] err_count,
  output logic          rts,
  output logic          req_full,
  output logic          req_err,
  output logic          req_brk,
  output logic          timeout_flag,
  output logic          overrun
);
  logic      done_ev, brk_ev, push_ok, pop_ok, armed, par_on;
  rx_entry_t new_char, head;
  logic [TW-1:0] idle_limit;

  assign par_on     = parity_enabled(cfg_parity);
  assign idle_limit = TW'(idle_ticks(TOUT_FRAMES, cfg_eight, par_on, cfg_two_stop));

  rx_frame_sampler u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick16),
    .rxd      (rxd),
    .eight    (cfg_eight),
    .two_stop (cfg_two_stop),
    .par_mode (cfg_parity),
    .done_ev  (done_ev),
    .brk_ev   (brk_ev),
    .char_o   (new_char)
  );

  rx_tag_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (done_ev),
    .push_entry (new_char),
    .pop        (rd_en),
    .head       (head),
    .count      (rx_count),
    .err_count  (err_count),
    .push_ok    (push_ok),
    .pop_ok     (pop_ok)
  );

  assign armed = (rx_count != '0) && (rx_count < rx_trig);

  rx_idle_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick16),
    .armed   (armed),
    .restart (done_ev || brk_ev),
    .clear   (pop_ok),
    .limit   (idle_limit),
    .flag    (timeout_flag)
  );

  assign rd_data  = head.data;
  assign rd_perr  = head.perr;
  assign rd_ferr  = head.ferr;
  assign rts      = rx_count < rts_level;
  assign req_full = rx_count >= rx_trig;
  assign req_err  = err_count != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_brk <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (brk_ev)        req_brk <= 1'b1;
      else if (flag_clr) req_brk <= 1'b0;
      if (done_ev && !push_ok) overrun <= 1'b1;
      else if (flag_clr)       overrun <= 1'b0;
    end
  end

  // R8
  brk_nostore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_ev && !rd_en) |=> $stable(rx_count));
  // R7
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(done_ev && rx_count == CW'(DEPTH)));
  // R5
  arrival_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ev && !rd_en && rx_count != CW'(DEPTH)) |=> rx_count == $past(rx_count) + CW'(1));
endmodule

// File: tb/async_rx_errfifo_bench.sv
module async_rx_errfifo_bench;
  localparam int DEPTH = 16;
  localparam int TOUT  = 15;
  localparam int CW    = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, tick16, rxd, cfg_eight, cfg_two_stop, rd_en, flag_clr;
  logic [1:0] cfg_parity;
  logic [CW-1:0] rx_trig, rts_level;
  logic [7:0] rd_data;
  logic rd_perr, rd_ferr, rts, req_full, req_err, req_brk, timeout_flag, overrun;
  logic [CW-1:0] rx_count, err_count;

  async_rx_errfifo #(.DEPTH(DEPTH), .TOUT_FRAMES(TOUT)) u_async_rx_errfifo (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_eight(cfg_eight), .cfg_two_stop(cfg_two_stop), .cfg_parity(cfg_parity),
    .rx_trig(rx_trig), .rts_level(rts_level), .rd_en(rd_en), .flag_clr(flag_clr),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
    .rx_count(rx_count), .err_count(err_count), .rts(rts), .req_full(req_full),
    .req_err(req_err), .req_brk(req_brk), .timeout_flag(timeout_flag), .overrun(overrun)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int unsigned qd[$];
  bit qp[$];
  bit qf[$];
  bit m_brk = 1'b0, m_ovr = 1'b0, m_tflag = 1'b0;
  int m_tcnt = 0;
  bit pend_push = 1'b0, pend_brk = 1'b0, pend_p = 1'b0, pend_f = 1'b0;
  int unsigned pend_data = 0;

  task automatic check(string tag, int unsigned act, int unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_errs();
    int n = 0;
    foreach (qd[i]) if (qp[i] || qf[i]) n++;
    return n;
  endfunction

  function automatic int model_limit();
    int bits;
    bits = 1 + (cfg_eight ? 8 : 7) + ((cfg_parity == 2'd1 || cfg_parity == 2'd2) ? 1 : 0)
         + (cfg_two_stop ? 2 : 1);
    return TOUT * bits * 16;
  endfunction

  task automatic model_edge();
    int sz;
    bit pop_ok, push_ok, armed;
    sz      = qd.size();
    pop_ok  = rd_en && sz > 0;
    push_ok = pend_push && sz < DEPTH;
    armed   = sz != 0 && sz < int'(rx_trig);
    if (pend_push || pend_brk || pop_ok) begin
      m_tcnt = 0;
      if (pop_ok) m_tflag = 1'b0;
    end else if (!armed) begin
      m_tcnt = 0;
    end else if (!m_tflag) begin
      if (m_tcnt == model_limit() - 1) begin
        m_tflag = 1'b1;
        m_tcnt = 0;
      end else m_tcnt++;
    end
    if (pop_ok) begin
      void'(qd.pop_front());
      void'(qp.pop_front());
      void'(qf.pop_front());
    end
    if (push_ok) begin
      qd.push_back(pend_data);
      qp.push_back(pend_p);
      qf.push_back(pend_f);
    end
    if (pend_brk) m_brk = 1'b1;
    else if (flag_clr) m_brk = 1'b0;
    if (pend_push && !push_ok) m_ovr = 1'b1;
    else if (flag_clr) m_ovr = 1'b0;
    pend_push = 1'b0;
    pend_brk  = 1'b0;
  endtask

  task automatic compare();
    int sz;
    sz = qd.size();
    check("R5 rx_count", rx_count, sz);
    check("R6 err_count", err_count, model_errs());
    check("R6 req_err", req_err, model_errs() != 0);
    check("R10 rts", rts, sz < int'(rts_level));
    check("R11 req_full", req_full, sz >= int'(rx_trig));
    check("R8 req_brk", req_brk, m_brk);
    check("R7 overrun", overrun, m_ovr);
    check("R9 timeout_flag", timeout_flag, m_tflag);
    if (sz > 0) begin
      check("R2 rd_data", rd_data, qd[0]);
      check("R3 rd_perr", rd_perr, qp[0]);
      check("R4 rd_ferr", rd_ferr, qf[0]);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic read_one();
    rd_en = 1'b1;
    cycle();
    rd_en = 1'b0;
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1;
    cycle();
    flag_clr = 1'b0;
  endtask

  task automatic set_cfg(bit eight, bit [1:0] par, bit two);
    cfg_eight = eight;
    cfg_parity = par;
    cfg_two_stop = two;
  endtask

  // Sends one frame; the final stop bit is sampled on iteration 8 of its period.
  task automatic send(int unsigned val, bit flip_par, bit bad_stop1, bit all_zero);
    bit bits[12];
    int n;
    int unsigned d;
    bit par_on, p;
    n = 0;
    par_on = (cfg_parity == 2'd1 || cfg_parity == 2'd2);
    d = val & (cfg_eight ? 32'hFF : 32'h7F);
    bits[n++] = 1'b0;
    for (int i = 0; i < (cfg_eight ? 8 : 7); i++) bits[n++] = d[i];
    if (par_on) begin
      p = (^d[7:0]) ^ (cfg_parity == 2'd2) ^ flip_par;
      bits[n++] = p;
    end
    bits[n++] = !bad_stop1;
    if (cfg_two_stop) bits[n++] = 1'b1;
    if (all_zero) for (int i = 0; i < n; i++) bits[i] = 1'b0;
    for (int b = 0; b < n; b++) begin
      rxd = bits[b];
      for (int s = 0; s < 16; s++) begin
        if (b == n - 1 && s == 8) begin
          if (all_zero) pend_brk = 1'b1;
          else begin
            pend_push = 1'b1;
            pend_data = d;
            pend_p    = par_on && flip_par;
            pend_f    = bad_stop1;
          end
        end
        cycle();
      end
    end
    if (!all_zero) rxd = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick16 = 1'b1; rxd = 1'b1; rd_en = 1'b0; flag_clr = 1'b0;
    set_cfg(1'b1, 2'd0, 1'b0);
    rx_trig = 5'd8; rts_level = 5'd12;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    check("R12 rx_count", rx_count, 0);
    check("R12 err_count", err_count, 0);
    check("R12 rts", rts, 1);
    check("R12 req_full", req_full, 0);
    check("R12 req_err", req_err, 0);
    check("R12 req_brk", req_brk, 0);
    check("R12 overrun", overrun, 0);
    check("R12 timeout_flag", timeout_flag, 0);
    idle(5);

    // R2 eight data bits, no parity, one stop
    send(32'h55, 0, 0, 0);
    send(32'hA3, 0, 0, 0);
    idle(4);
    check("R2 first char", rd_data, 8'h55);
    read_one();
    check("R2 second char", rd_data, 8'hA3);
    read_one();

    // R2 seven bits, R3 even parity
    set_cfg(1'b0, 2'd1, 1'b0);
    send(32'h5A, 0, 0, 0);
    send(32'hC5, 0, 0, 0);
    send(32'h33, 1, 0, 0);
    idle(4);
    check("R6 one tagged entry", err_count, 1);
    check("R2 seven-bit head", rd_data, 8'h5A);
    read_one();
    check("R2 seven-bit msb clear", rd_data, 8'h45);
    read_one();
    check("R3 even parity flag", rd_perr, 1);
    read_one();

    // R3 odd parity, R4 two stop bits with a bad first stop
    set_cfg(1'b1, 2'd2, 1'b1);
    send(32'h81, 0, 0, 0);
    send(32'h10, 0, 1, 0);
    send(32'h0F, 1, 0, 0);
    idle(4);
    check("R6 two tagged entries", err_count, 2);
    check("R3 odd parity clean", rd_perr, 0);
    read_one();
    check("R4 framing flag", rd_ferr, 1);
    read_one();
    check("R3 odd parity flag", rd_perr, 1);
    read_one();

    // R1 short glitch is not a start bit
    set_cfg(1'b1, 2'd0, 1'b0);
    rxd = 1'b0;
    idle(4);
    rxd = 1'b1;
    idle(30);
    check("R1 glitch stores nothing", rx_count, 0);

    // R8 break: whole frame low
    send(32'h0, 0, 0, 1);
    idle(20);
    rxd = 1'b1;
    idle(20);
    check("R8 break raised", req_brk, 1);
    check("R8 break not stored", rx_count, 0);
    send(32'h42, 0, 0, 0);
    idle(4);
    check("R8 receive after break", rd_data, 8'h42);
    clear_flags();
    check("R8 break cleared", req_brk, 0);

    // R9 time-out with data below trigger
    send(32'h24, 0, 0, 0);
    idle(model_limit() + 20);
    check("R9 time-out set", timeout_flag, 1);
    read_one();
    check("R9 read clears time-out", timeout_flag, 0);
    read_one();

    // R7 overrun, R10 flow control, R11 fill request
    for (int i = 0; i < DEPTH + 1; i++) send(32'(i * 7 + 1), 0, 0, 0);
    idle(4);
    check("R7 overrun set", overrun, 1);
    check("R5 queue full", rx_count, DEPTH);
    check("R10 rts low when full", rts, 0);
    check("R11 fill request", req_full, 1);
    for (int i = 0; i < DEPTH; i++) begin
      check("R5 drain order", rd_data, 32'(i * 7 + 1));
      read_one();
    end
    check("R10 rts back high", rts, 1);
    clear_flags();
    check("R7 overrun cleared", overrun, 0);
    idle(10);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule